// File: doc/BRIEF.md
# Synchronous Character Receiver with Sync Hunt

This block receives a serial bit stream and finds character boundaries without any framing bits. After reset, and after every hunt command, it is in the hunting state. In that state it shifts each accepted bit into a history register. After every shift it compares the most recent bits with a programmed sync pattern. The pattern length can be 6, 8, 12 or 16 bits and is chosen by a two-bit code.

Once the pattern is found, the block raises its sync flag. It then assembles every following group of eight bits into a byte and offers that byte for one cycle on a valid/ready push interface toward a receive FIFO. If the FIFO is not ready, the byte is dropped and a sticky overrun flag is raised. Software or a dropout detector issues the hunt command to force resynchronisation.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, `sync_found`, `out_valid` and `overrun` are low, the receiver is hunting, and the bit history is empty.
- R2: While hunting, each cycle with `bit_valid` high shifts `bit_in` into the history. When the most recent N received bits equal `sync_pat[N-1:0]`, `sync_found` is high from the next clock edge. The oldest of the N bits is compared with `sync_pat[N-1]` and the newest with `sync_pat[0]`.
- R3: N is selected by `len_sel` as follows: 2'b01 gives 12, 2'b00 gives 16, 2'b11 gives 6 and 2'b10 gives 8.
- R4: A match is only accepted once at least N bits have been shifted in since the last reset or hunt command. Cleared history never counts as received bits.
- R5: Once synchronised, each run of 8 accepted bits forms one byte. The first bit of the run lands in `out_data[7]`. `out_valid` is high for exactly the one cycle that follows the 8th bit, and `out_data` holds the byte during that cycle. The first run begins with the bit after the sync pattern.
- R6: A cycle with `hunt_cmd` high returns the receiver to hunting at the next edge. At that edge it clears `sync_found`, `out_valid`, `overrun`, the history and the character bit count. A bit offered in that same cycle is discarded.
- R7: If `out_valid` is high while `out_ready` is low, that byte is lost and `overrun` is high from the next edge. `overrun` stays high until a hunt command or reset.
- R8: Cycles with `bit_valid` low shift nothing and count nothing. The hunting or synchronised state is unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Serial data bit |
| sync_pat | input | 16 | Sync pattern; the low N bits are used |
| len_sel | input | 2 | Sync length code (see R3) |
| hunt_cmd | input | 1 | Enter hunting state |
| out_valid | output | 1 | Received byte offered |
| out_ready | input | 1 | FIFO can take the byte |
| out_data | output | 8 | Received byte, first bit in bit 7 |
| sync_found | output | 1 | Receiver is synchronised |
| overrun | output | 1 | Sticky lost-byte flag |

## Verification
A wrong history or a wrong length mask shows up at the ports as `sync_found` rising one accepted bit early or late, or not rising at all. The bench sees this on the edge right after the pattern's last bit. A slipped character count shows eight bits later: `out_valid` appears in the wrong cycle, or `out_data` is rotated. The bench compares every port after every cycle against a model written from the requirements. Random prefixes, idle gaps, backpressure and mid-stream hunt commands expose any divergence within one character time.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

   localparam int unsigned PAT_MAX = 16;

   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_SYNC = 1'b1
   } rx_state_e;

   // Length code: {len_sel[1], len_sel[0]}
   function automatic logic [4:0] sync_len(input logic [1:0] code);
      logic [4:0] n;
      case (code)
         2'b01:   n = 5'd12;
         2'b00:   n = 5'd16;
         2'b11:   n = 5'd6;
         default: n = 5'd8;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/srx_hunt_shifter.sv
module srx_hunt_shifter
   import sync_rx_pkg::*;
#(
   parameter int unsigned PAT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift_en,
   input  logic             bit_in,
   input  logic [1:0]       len_code,
   input  logic [PAT_W-1:0] pattern,
   output logic             hit
);
   localparam int unsigned FILL_W = $clog2(PAT_W + 1);

   generate
      if (PAT_W < PAT_MAX) begin : g_bad_width
         $error("srx_hunt_shifter: PAT_W must cover the longest sync length");
      end
   endgenerate

   logic [PAT_W-1:0]  hist_q;
   logic [PAT_W-1:0]  hist_nxt;
   logic [FILL_W-1:0] fill_q;
   logic [FILL_W-1:0] fill_nxt;
   logic [PAT_W-1:0]  mask;
   logic [4:0]        len_n;
   logic              full_enough;

   assign len_n    = sync_len(len_code);
   assign hist_nxt = {hist_q[PAT_W-2:0], bit_in};
   assign fill_nxt = (fill_q == FILL_W'(PAT_W)) ? fill_q : fill_q + 1'b1;

   generate
      for (genvar i = 0; i < PAT_W; i++) begin : g_mask
         assign mask[i] = (i < int'(len_n));
      end
   endgenerate

   assign full_enough = (int'(fill_nxt) >= int'(len_n));
   assign hit = shift_en && full_enough && (((hist_nxt ^ pattern) & mask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (clr) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (shift_en) begin
         hist_q <= hist_nxt;
         fill_q <= fill_nxt;
      end
   end

   a_r4_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fill_q) <= PAT_W);

   a_r4_hit_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !shift_en) |=> !hit || (int'(len_n) <= 1));

endmodule

// File: rtl/srx_char_builder.sv
module srx_char_builder #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              bit_en,
   input  logic              bit_in,
   output logic              done,
   output logic [CHAR_W-1:0] data
);
   localparam int unsigned CNT_W = $clog2(CHAR_W);

   generate
      if (CHAR_W < 2) begin : g_bad_char
         $error("srx_char_builder: CHAR_W must be at least 2");
      end
   endgenerate

   logic [CHAR_W-2:0] acc_q;
   logic [CNT_W-1:0]  cnt_q;

   assign done = bit_en && (cnt_q == CNT_W'(CHAR_W - 1));
   assign data = {acc_q, bit_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (bit_en) begin
         acc_q <= data[CHAR_W-2:0];
         cnt_q <= done ? '0 : cnt_q + 1'b1;
      end
   end

   a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) < CHAR_W);

   a_r8_idle_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/srx_push_stage.sv
module srx_push_stage #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [CHAR_W-1:0] load_data,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [CHAR_W-1:0] out_data,
   output logic              overrun
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         overrun   <= 1'b0;
      end else if (clr) begin
         out_valid <= 1'b0;
         overrun   <= 1'b0;
      end else begin
         out_valid <= load;
         if (load) begin
            out_data <= load_data;
         end
         if (out_valid && !out_ready) begin
            overrun <= 1'b1;
         end
      end
   end

   a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !clr) |=> overrun);

   a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !clr) |=> overrun);

endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
   import sync_rx_pkg::*;
#(
   parameter int unsigned PAT_W  = 16,
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_valid,
   input  logic              bit_in,
   input  logic [PAT_W-1:0]  sync_pat,
   input  logic [1:0]        len_sel,
   input  logic              hunt_cmd,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [CHAR_W-1:0] out_data,
   output logic              sync_found,
   output logic              overrun
);
   rx_state_e         state_q;
   logic              hunt_shift;
   logic              sync_shift;
   logic              hit;
   logic              char_done;
   logic [CHAR_W-1:0] char_data;

   assign hunt_shift = bit_valid && !hunt_cmd && (state_q == ST_HUNT);
   assign sync_shift = bit_valid && !hunt_cmd && (state_q == ST_SYNC);
   assign sync_found = (state_q == ST_SYNC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
      end else if (hunt_cmd) begin
         state_q <= ST_HUNT;
      end else if (hit) begin
         state_q <= ST_SYNC;
      end
   end

   srx_hunt_shifter #(.PAT_W(PAT_W)) u_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (hunt_cmd),
      .shift_en (hunt_shift),
      .bit_in   (bit_in),
      .len_code (len_sel),
      .pattern  (sync_pat),
      .hit      (hit)
   );

   srx_char_builder #(.CHAR_W(CHAR_W)) u_builder (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (hunt_cmd),
      .bit_en (sync_shift),
      .bit_in (bit_in),
      .done   (char_done),
      .data   (char_data)
   );

   srx_push_stage #(.CHAR_W(CHAR_W)) u_push (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (hunt_cmd),
      .load      (char_done),
      .load_data (char_data),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .overrun   (overrun)
   );

   a_r2_sync_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_found) |-> $past(bit_valid) && !$past(hunt_cmd));

   a_r6_hunt_clears: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_cmd |=> (!sync_found && !out_valid && !overrun));

   a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   a_r5_valid_only_synced: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(sync_found));

   a_r8_idle_state: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_valid && !hunt_cmd) |=> $stable(sync_found));

endmodule

// File: tb/sync_hunt_rx_bench.sv
module sync_hunt_rx_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_valid = 1'b0, bit_in = 1'b0, hunt_cmd = 1'b0, out_ready = 1'b1;
   logic [15:0] sync_pat = '0;
   logic [1:0]  len_sel = 2'b00;
   logic        out_valid, sync_found, overrun;
   logic [7:0]  out_data;

   int checks = 0, errors = 0, cycles = 0;

   // model state
   logic        m_sync = 0, m_v = 0, m_ovr = 0;
   logic [15:0] m_hist = 0;
   int          m_fill = 0, m_cnt = 0;
   logic [7:0]  m_acc = 0, m_d = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_hunt_rx u_sync_hunt_rx (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .sync_pat(sync_pat), .len_sel(len_sel), .hunt_cmd(hunt_cmd),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .sync_found(sync_found), .overrun(overrun)
   );

   function automatic int len_of(input logic [1:0] c);
      case (c)
         2'b01: return 12;
         2'b00: return 16;
         2'b11: return 6;
         default: return 8;
      endcase
   endfunction

   function automatic logic low_match(input logic [15:0] h, input logic [15:0] p, input int n);
      for (int i = 0; i < n; i++) if (h[i] != p[i]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   task automatic model(input logic v, input logic b, input logic h, input logic rdy);
      if (h) begin
         m_sync = 0; m_v = 0; m_ovr = 0; m_hist = 0; m_fill = 0; m_cnt = 0; m_acc = 0;
      end else begin
         if (m_v && !rdy) m_ovr = 1;
         m_v = 0;
         if (v) begin
            if (!m_sync) begin
               m_hist = {m_hist[14:0], b};
               if (m_fill < 16) m_fill++;
               if (m_fill >= len_of(len_sel) && low_match(m_hist, sync_pat, len_of(len_sel))) begin
                  m_sync = 1; m_cnt = 0;
               end
            end else begin
               m_acc = {m_acc[6:0], b};
               m_cnt++;
               if (m_cnt == 8) begin
                  m_v = 1; m_d = m_acc; m_cnt = 0;
               end
            end
         end
      end
   endtask

   task automatic step(input logic v, input logic b, input logic h, input logic rdy);
      @(negedge clk);
      bit_valid = v; bit_in = b; hunt_cmd = h; out_ready = rdy;
      model(v, b, h, rdy);
      @(posedge clk);
      #1;
      if (h) begin
         check("R6 sync_found after hunt", {7'd0, sync_found}, 8'd0);
         check("R6 overrun after hunt", {7'd0, overrun}, 8'd0);
      end else if (!v) begin
         check("R8 sync_found idle", {7'd0, sync_found}, {7'd0, m_sync});
      end else begin
         check("R2 R3 R4 sync_found", {7'd0, sync_found}, {7'd0, m_sync});
      end
      check("R5 out_valid", {7'd0, out_valid}, {7'd0, m_v});
      if (m_v) check("R5 out_data", out_data, m_d);
      check("R7 overrun", {7'd0, overrun}, {7'd0, m_ovr});
   endtask

   task automatic send_pattern(input logic [15:0] p, input int n);
      for (int i = n - 1; i >= 0; i--) step(1'b1, p[i], 1'b0, 1'b1);
   endtask

   task automatic enter_hunt(input logic [1:0] code, input logic [15:0] p);
      @(negedge clk);
      len_sel = code; sync_pat = p;
      step(1'b1, 1'b1, 1'b1, 1'b1);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned junk;
      logic [1:0] codes [4] = '{2'b01, 2'b00, 2'b11, 2'b10};
      junk = $urandom(32'h5eed);
      repeat (3) @(posedge clk);
      #1;
      check("R1 sync_found reset", {7'd0, sync_found}, 8'd0);
      check("R1 out_valid reset", {7'd0, out_valid}, 8'd0);
      check("R1 overrun reset", {7'd0, overrun}, 8'd0);
      @(negedge clk); rst_n = 1'b1;

      // R3: every length code, random pattern, random prefix and data
      for (int r = 0; r < 6; r++) begin
         foreach (codes[k]) begin
            logic [15:0] p;
            p = 16'($urandom);
            enter_hunt(codes[k], p);
            for (int i = 0; i < 10; i++) step(1'b1, 1'($urandom), 1'b0, 1'b1);
            send_pattern(p, len_of(codes[k]));
            for (int i = 0; i < 60; i++)
               step(($urandom % 4) != 0, 1'($urandom), 1'b0, ($urandom % 8) != 0);
         end
      end

      // R4: all-zero 6-bit pattern needs six bits after hunt
      enter_hunt(2'b11, 16'h0000);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b1);
      check("R4 no early sync", {7'd0, sync_found}, 8'd0);
      step(1'b1, 1'b0, 1'b0, 1'b1);
      check("R4 sync on sixth bit", {7'd0, sync_found}, 8'd1);

      // R5: directed byte A5, first bit to bit 7, idle gaps in between
      for (int i = 7; i >= 0; i--) begin
         step(1'b0, 1'b1, 1'b0, 1'b1);
         step(1'b1, 8'hA5 >> i, 1'b0, 1'b1);
      end
      check("R5 directed byte valid", {7'd0, out_valid}, 8'd1);
      check("R5 directed byte data", out_data, 8'hA5);

      // R7: backpressure drops byte, overrun sticky
      for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      check("R7 overrun raised", {7'd0, overrun}, 8'd1);
      for (int i = 0; i < 20; i++) step(1'b1, 1'($urandom), 1'b0, 1'b1);
      check("R7 overrun sticky", {7'd0, overrun}, 8'd1);

      // R6: hunt mid-character, concurrent bit ignored, 16-bit resync
      enter_hunt(2'b00, 16'hF0A3);
      check("R6 hunting after command", {7'd0, sync_found}, 8'd0);
      send_pattern(16'hF0A3, 16);
      check("R6 resync after hunt", {7'd0, sync_found}, 8'd1);
      for (int i = 0; i < 40; i++) step(1'b1, 1'($urandom), 1'b0, 1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule